// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by an integer N and emits one single-cycle pulse per N input cycles. It is the feedback path of an integer-N frequency synthesizer. A prescaler divides by either P or P+1. Two down-counters steer that prescaler: a swallow count A and a main count B.

At the start of every output period the prescaler runs at P+1 for A of its own periods. It then runs at P for the remaining B−A periods. The total ratio is therefore N = B·P + A. The modulus-control level is also brought out as a port.

A synchronous load port writes a new A, B and prescaler code into a holding latch. The latch passes its contents to the counters only at the next period boundary, so a reload never cuts a period short. Values that break the ordering rules are refused and raise a flag. A synchronous counter reset restarts the period from the held values and keeps the output low while it is asserted.

Top module: `dm_feedback_div`

## Requirements
- R1: Each output period lasts exactly B·P + A input cycles, where A, B and P are the active settings.
- R2: The 2-bit prescaler code selects the base modulus: 0 gives P=8, 1 gives P=16, 2 gives P=32 and 3 gives P=64. The high modulus is always P+1.
- R3: Within one period, mod_o is high for the first A·(P+1) cycles and low for the rest of the period. mod_o rises only in the first cycle of a period.
- R4: div_o is high for exactly one input cycle per period, in the first cycle of the next period.
- R5: A load with B < A or B < 3 sets cfg_err_o in the cycle after the load and leaves the active and held settings unchanged.
- R6: A valid load clears cfg_err_o in the cycle after the load.
- R7: A valid load does not change the length of the period in progress. The new settings govern the period that starts at the next boundary.
- R8: While cnt_rst_i is high, div_o stays low. After cnt_rst_i falls, the first pulse arrives N cycles later, with N computed from the held settings.
- R9: After asynchronous reset, div_o and cfg_err_o are low and the settings are A=5, B=16, code 0. This gives a first period of 133 cycles.
- R10: The extremes A=0 (mod_o never high, N = B·P) and A=B (mod_o high for the whole period, N = B·(P+1)) divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_rst_i | input | 1 | Synchronous counter restart from held settings |
| ld_valid_i | input | 1 | Load strobe for the settings below |
| ld_a_i | input | 6 | Swallow count A |
| ld_b_i | input | 13 | Main count B |
| ld_psel_i | input | 2 | Prescaler code |
| div_o | output | 1 | One-cycle pulse per output period |
| mod_o | output | 1 | Modulus control, high while dividing by P+1 |
| cfg_err_o | output | 1 | Last load was refused |

## Verification
A prescaler that miscounts shows up within one period as a pulse spacing off by a multiple of the swallowed periods. A swallow counter that stops at the wrong value changes the count of mod_o-high cycles within the same period. A boundary transfer that fires early shows up as a shortened period directly after a mid-period reload. The same defect after a counter restart shows up in the first pulse after release. A wrong validation decision is visible on cfg_err_o one cycle after the load, and in the next period's length.

// File: rtl/dm_div_pkg.sv
package dm_div_pkg;
  parameter int A_W  = 6;
  parameter int B_W  = 13;
  parameter int PS_W = 2;
  parameter int BASE_MIN = 8;
  parameter int PC_W = $clog2((BASE_MIN << ((1 << PS_W) - 1)) + 2);
  parameter int B_MIN = 3;

  typedef struct packed {
    logic [A_W-1:0]  a;
    logic [B_W-1:0]  b;
    logic [PS_W-1:0] ps;
  } div_cfg_t;

  function automatic logic [PC_W-1:0] base_mod(logic [PS_W-1:0] ps);
    return PC_W'(BASE_MIN) << ps;
  endfunction

  function automatic logic cfg_ok(div_cfg_t c);
    return (c.b >= B_W'(c.a)) && (c.b >= B_W'(B_MIN));
  endfunction
endpackage

// File: rtl/dm_cfg_latch.sv
module dm_cfg_latch
  import dm_div_pkg::*;
#(
  parameter div_cfg_t RST_CFG = '{a: 6'd5, b: 13'd16, ps: 2'd0}
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ld_valid_i,
  input  div_cfg_t ld_cfg_i,
  output div_cfg_t hold_o,
  output logic     err_o
);
  logic ok;
  assign ok = cfg_ok(ld_cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= RST_CFG;
      err_o  <= 1'b0;
    end else if (ld_valid_i) begin
      err_o <= !ok;
      if (ok) hold_o <= ld_cfg_i;
    end
  end
endmodule

// File: rtl/dm_prescaler.sv
module dm_prescaler
  import dm_div_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            mod_i,
  output logic            tick_o
);
  logic [PC_W-1:0] pcnt, base, last;

  assign base   = base_mod(ps_i);
  // high modulus spans one extra input cycle
  assign last   = mod_i ? base : base - PC_W'(1);
  assign tick_o = (pcnt == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt <= '0;
    else if (restart_i || tick_o) pcnt <= '0;
    else                        pcnt <= pcnt + PC_W'(1);
  end
endmodule

// File: rtl/dm_swallow_ctr.sv
module dm_swallow_ctr
  import dm_div_pkg::*;
#(
  parameter div_cfg_t RST_CFG = '{a: 6'd5, b: 13'd16, ps: 2'd0}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            crst_i,
  input  logic            tick_i,
  input  div_cfg_t        hold_i,
  output logic            mod_o,
  output logic            end_o,
  output logic [PS_W-1:0] ps_o
);
  logic [A_W-1:0] acnt;
  logic [B_W-1:0] bcnt;

  assign mod_o = (acnt != '0);
  assign end_o = tick_i && (bcnt == B_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt <= RST_CFG.a;
      bcnt <= RST_CFG.b;
      ps_o <= RST_CFG.ps;
    end else if (crst_i || end_o) begin
      // boundary transfer from the holding latch
      acnt <= hold_i.a;
      bcnt <= hold_i.b;
      ps_o <= hold_i.ps;
    end else if (tick_i) begin
      bcnt <= bcnt - B_W'(1);
      if (mod_o) acnt <= acnt - A_W'(1);
    end
  end
endmodule

// File: rtl/dm_feedback_div.sv
module dm_feedback_div
  import dm_div_pkg::*;
#(
  parameter div_cfg_t RST_CFG = '{a: 6'd5, b: 13'd16, ps: 2'd0}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_rst_i,
  input  logic            ld_valid_i,
  input  logic [A_W-1:0]  ld_a_i,
  input  logic [B_W-1:0]  ld_b_i,
  input  logic [PS_W-1:0] ld_psel_i,
  output logic            div_o,
  output logic            mod_o,
  output logic            cfg_err_o
);
  div_cfg_t        ld_cfg, hold;
  logic            tick, per_end;
  logic [PS_W-1:0] act_ps;

  assign ld_cfg = '{a: ld_a_i, b: ld_b_i, ps: ld_psel_i};

  dm_cfg_latch #(.RST_CFG(RST_CFG)) u_latch (
    .clk_i, .rst_ni, .ld_valid_i, .ld_cfg_i(ld_cfg), .hold_o(hold), .err_o(cfg_err_o)
  );

  dm_prescaler u_pre (
    .clk_i, .rst_ni, .restart_i(cnt_rst_i), .ps_i(act_ps), .mod_i(mod_o), .tick_o(tick)
  );

  dm_swallow_ctr #(.RST_CFG(RST_CFG)) u_ctr (
    .clk_i, .rst_ni, .crst_i(cnt_rst_i), .tick_i(tick), .hold_i(hold),
    .mod_o, .end_o(per_end), .ps_o(act_ps)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_o <= 1'b0;
    else         div_o <= per_end && !cnt_rst_i;
  end
endmodule

// File: rtl/dm_div_chk.sv
module dm_div_chk
  import dm_div_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cnt_rst_i,
  input logic            ld_valid_i,
  input logic [A_W-1:0]  ld_a_i,
  input logic [B_W-1:0]  ld_b_i,
  input logic            div_o,
  input logic            mod_o,
  input logic            cfg_err_o
);
  logic bad_ld;
  assign bad_ld = (ld_b_i < B_W'(ld_a_i)) || (ld_b_i < B_W'(B_MIN));

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o); // R4
  AST_CRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_i |=> !div_o); // R8
  AST_BAD_LOAD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && bad_ld) |=> cfg_err_o); // R5
  AST_GOOD_LOAD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && !bad_ld) |=> !cfg_err_o); // R6
  AST_MOD_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_o) |-> (div_o || $past(cnt_rst_i))); // R3
  AST_ERR_ONLY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> $stable(cfg_err_o)); // R5
endmodule

bind dm_feedback_div dm_div_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_rst_i(cnt_rst_i), .ld_valid_i(ld_valid_i),
  .ld_a_i(ld_a_i), .ld_b_i(ld_b_i), .div_o(div_o), .mod_o(mod_o), .cfg_err_o(cfg_err_o)
);

// File: tb/dm_feedback_div_tb.sv
module dm_feedback_div_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_rst_i = 1'b0;
  logic        ld_valid_i = 1'b0;
  logic [5:0]  ld_a_i = '0;
  logic [12:0] ld_b_i = '0;
  logic [1:0]  ld_psel_i = '0;
  logic        div_o, mod_o, cfg_err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dm_feedback_div dut_i (.*);

  function automatic int exp_n(int a, int b, int ps);
    return b * (8 << ps) + a;
  endfunction
  function automatic int exp_m(int a, int ps);
    return a * ((8 << ps) + 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic load(int a, int b, int ps);
    @(negedge clk_i);
    ld_valid_i = 1'b1; ld_a_i = 6'(a); ld_b_i = 13'(b); ld_psel_i = 2'(ps);
    @(negedge clk_i);
    ld_valid_i = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk_i); while (!div_o);
  endtask

  // call at a negedge where div_o is high
  task automatic measure(output int n, output int m);
    m = int'(mod_o);
    n = 0;
    forever begin
      @(negedge clk_i);
      n++;
      if (div_o) break;
      m += int'(mod_o);
    end
  endtask

  task automatic run_cfg(string tag, int a, int b, int ps);
    int n, m;
    load(a, b, ps);
    wait_pulse();
    measure(n, m);
    chk({tag, " period"}, n, exp_n(a, b, ps));
    chk({tag, " mod cycles"}, m, exp_m(a, ps));
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, m;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    chk("R9 div_o in reset", int'(div_o), 0);
    chk("R9 cfg_err_o in reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!div_o);
    chk("R9 R1 first period", n, 133);
    measure(n, m);
    chk("R1 default period", n, 133);
    chk("R3 default mod cycles", m, 45);
    @(negedge clk_i);
    chk("R4 pulse width", int'(div_o), 0);

    for (int ps = 0; ps < 4; ps++) run_cfg("R2 R1 code", 7, 20, ps);
    run_cfg("R10 a=0", 0, 10, 1);
    run_cfg("R10 a=b", 12, 12, 0);
    run_cfg("R10 b=3", 3, 3, 3);
    run_cfg("R1 base", 4, 30, 0);

    // refused loads
    load(10, 5, 0);
    chk("R5 flag b<a", int'(cfg_err_o), 1);
    wait_pulse(); measure(n, m);
    chk("R5 period kept", n, 244);
    load(2, 2, 0);
    chk("R5 flag b<3", int'(cfg_err_o), 1);
    wait_pulse(); measure(n, m);
    chk("R5 period kept b<3", n, 244);
    chk("R5 mod kept", m, 36);
    load(4, 30, 0);
    chk("R6 flag cleared", int'(cfg_err_o), 0);

    // mid-period reload
    wait_pulse();
    n = 0;
    repeat (5) begin @(negedge clk_i); n++; end
    ld_valid_i = 1'b1; ld_a_i = 6'd9; ld_b_i = 13'd40; ld_psel_i = 2'd1;
    @(negedge clk_i); n++;
    ld_valid_i = 1'b0;
    while (!div_o) begin @(negedge clk_i); n++; end
    chk("R7 current period kept", n, 244);
    measure(n, m);
    chk("R7 new period", n, 649);
    chk("R7 new mod cycles", m, 153);

    // counter restart picks up held values
    repeat (20) @(negedge clk_i);
    load(5, 20, 0);
    cnt_rst_i = 1'b1;
    m = 0;
    repeat (6) begin @(negedge clk_i); m += int'(div_o); end
    chk("R8 div_o low in restart", m, 0);
    cnt_rst_i = 1'b0;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!div_o);
    chk("R8 first period after restart", n, 165);

    for (int i = 0; i < 6; i++) begin
      int a, b, ps;
      a  = int'($urandom % 64);
      b  = ((a < 3) ? 3 : a) + int'($urandom % 16);
      ps = int'($urandom % 4);
      run_cfg("R1 R3 random", a, b, ps);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule